// File: doc/BRIEF.md
# I/O Port Window Decoder with Byte-Lane Strobes

This block watches an isolated I/O bus and turns each port access into active-low select strobes for one window of eight byte-wide ports. Each cycle it samples a 16-bit port address, a flag that marks the cycle as I/O rather than memory, read and write commands, two byte-bank enables (low bank and high bank) and a flag that marks a 32-bit access. It produces one select per port in the window. It also produces one write strobe per byte bank, so that each bank's latch is clocked on its own. On the read side it gives one enable per even/odd port pair, which would drive the tri-state buffers of an input port. The processor keeps only the byte it wants from the pair.

A configuration pin picks the decode width. In narrow mode only the low address byte is compared, for small dedicated systems that never use the upper byte. In wide mode all sixteen bits are compared. A 32-bit access that starts off a four-port boundary raises an error flag, and that cycle drives no strobe.

All outputs are registered on the bus clock. There is no data path and no handshake: every pin is a plain level.

Top module: `ioport_strobe_dec`

## Requirements
- R1: With `wide_mode`=0, the window is ports F0h–F7h and only `addr[7:0]` is compared. `addr[15:8]` has no effect; for example, 12F2h and 00F2h decode the same way.
- R2: With `wide_mode`=1, all of `addr[15:0]` is compared and the window is EFF8h–EFFFh. An address that matches only in its low byte, such as 00F2h, drives no strobe.
- R3: A strobe may assert only when `io_cycle`=1, at least one of `rd_cmd` and `wr_cmd` is 1, and the address is in the window. With `io_cycle`=0 (memory cycle) every output stays idle.
- R4: The window offset is `addr[2:0]` and the pair index is p = `addr[2:1]`. `addr[0]` is not decoded for byte or word accesses. For a non-32-bit access, `port_sel_n[2p]` goes low when `lane_lo_en`=1 and `port_sel_n[2p+1]` goes low when `lane_hi_en`=1. With neither enable set, no strobe asserts.
- R5: On a write, `wr_lane_n[0]` is low when an even port is selected and `wr_lane_n[1]` is low when an odd port is selected. With both bank enables set, both go low in the same cycle. On a read, neither asserts.
- R6: On a read, exactly one enable `rd_pair_n[p]` goes low for each pair that has at least one selected port, whichever bank enables are set. On a write, no read enable asserts.
- R7: When `xfer_dword`=1 and `addr[1:0]`=00, the four ports of group `addr[2]` are selected and the bank enables are ignored. A write drives both bank strobes. A read drives the two read enables of that group.
- R8: When `xfer_dword`=1 and `addr[1:0]`≠00, in an active in-window cycle `align_err` is 1 and every strobe stays high. `align_err` is 0 in all other cycles.
- R9: Outputs are registered. Inputs sampled at one rising edge show on the outputs after that edge, and strobes go high again in the cycle after the command is removed. Reset drives every strobe high and `align_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wide_mode | input | 1 | 0: compare the low address byte only; 1: compare all 16 bits |
| addr | input | 16 | Port address |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_cmd | input | 1 | Read command, active high |
| wr_cmd | input | 1 | Write command, active high |
| lane_lo_en | input | 1 | Low byte-bank enable (even port) |
| lane_hi_en | input | 1 | High byte-bank enable (odd port) |
| xfer_dword | input | 1 | 1 = 32-bit access |
| port_sel_n | output | 8 | Per-port select, active low |
| wr_lane_n | output | 2 | Write strobe per byte bank, active low, [0]=low bank |
| rd_pair_n | output | 4 | Read enable per port pair, active low |
| align_err | output | 1 | Misaligned 32-bit access in the window |

## Verification
The hardest cases to reach from the ports are two. One is a misaligned 32-bit access that is active and inside the window. The other is the narrow-mode alias, where a non-zero upper address byte must not change the outcome. The sweep covers every low address byte against three upper bytes (00h, EFh, FFh) in both modes. For each address it applies every combination of the I/O flag, the two commands, the two bank enables and the 32-bit flag. This lands on every offset of both windows with every misalignment, and on the addresses just outside each window. Each vector is followed at once by the next, so the one-cycle release of the strobes is checked throughout the run.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } decode_mode_e;

  typedef struct packed {
    logic io;
    logic rd;
    logic wr;
    logic lo;
    logic hi;
    logic dword;
  } bus_req_t;

endpackage

// File: rtl/ioport_window_match.sv
module ioport_window_match
  import ioport_pkg::*;
#(
  parameter int                  ADDR_W      = 16,
  parameter int                  NARROW_W    = 8,
  parameter int                  WIN_LOG2    = 3,
  parameter logic [NARROW_W-1:0] NARROW_BASE = 8'hF0,
  parameter logic [ADDR_W-1:0]   WIDE_BASE   = 16'hEFF8
) (
  input  logic [ADDR_W-1:0] addr,
  input  decode_mode_e      mode,
  output logic              hit
);

  logic narrow_hit;
  logic wide_hit;

  assign narrow_hit = (addr[NARROW_W-1:WIN_LOG2] == NARROW_BASE[NARROW_W-1:WIN_LOG2]);
  assign wide_hit   = (addr[ADDR_W-1:WIN_LOG2]   == WIDE_BASE[ADDR_W-1:WIN_LOG2]);

  always_comb begin
    unique case (mode)
      MODE_WIDE:   hit = wide_hit;
      default:     hit = narrow_hit;
    endcase
  end

endmodule

// File: rtl/ioport_lane_select.sv
module ioport_lane_select
  import ioport_pkg::*;
#(
  parameter int WIN_LOG2 = 3,
  localparam int NPORT   = 1 << WIN_LOG2,
  localparam int NPAIR   = NPORT / 2
) (
  input  logic [WIN_LOG2-1:0] offset,
  input  bus_req_t            req,
  input  logic                hit,
  output logic [NPORT-1:0]    port_mask,
  output logic [1:0]          wr_lane,
  output logic [NPAIR-1:0]    rd_pair,
  output logic                align_err
);

  logic active;
  logic misalign;
  logic go;
  logic [NPAIR-1:0] even_vec;
  logic [NPAIR-1:0] odd_vec;

  assign active    = hit & req.io & (req.rd | req.wr);
  assign misalign  = req.dword & (offset[1:0] != 2'b00);
  assign go        = active & ~misalign;
  assign align_err = active & misalign;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic [WIN_LOG2-2:0] PIDX = (WIN_LOG2-1)'(p);
    localparam logic [WIN_LOG2-3:0] GIDX = (WIN_LOG2-2)'(p / 2);
    logic in_word;
    logic in_group;
    logic even_t;
    logic odd_t;

    assign in_word  = (offset[WIN_LOG2-1:1] == PIDX);
    assign in_group = (offset[WIN_LOG2-1:2] == GIDX);
    assign even_t   = req.dword ? in_group : (in_word & req.lo);
    assign odd_t    = req.dword ? in_group : (in_word & req.hi);

    assign even_vec[p]        = go & even_t;
    assign odd_vec[p]         = go & odd_t;
    assign port_mask[2*p]     = even_vec[p];
    assign port_mask[2*p + 1] = odd_vec[p];
    assign rd_pair[p]         = req.rd & (even_vec[p] | odd_vec[p]);
  end

  assign wr_lane[0] = req.wr & (|even_vec);
  assign wr_lane[1] = req.wr & (|odd_vec);

endmodule

// File: rtl/ioport_strobe_reg.sv
module ioport_strobe_reg #(
  parameter int NPORT = 8,
  parameter int NPAIR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] port_mask,
  input  logic [1:0]       wr_lane,
  input  logic [NPAIR-1:0] rd_pair,
  input  logic             err_in,
  output logic [NPORT-1:0] port_sel_n,
  output logic [1:0]       wr_lane_n,
  output logic [NPAIR-1:0] rd_pair_n,
  output logic             align_err
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_sel_n <= '1;
      wr_lane_n  <= '1;
      rd_pair_n  <= '1;
      align_err  <= 1'b0;
    end else begin
      port_sel_n <= ~port_mask;
      wr_lane_n  <= ~wr_lane;
      rd_pair_n  <= ~rd_pair;
      align_err  <= err_in;
    end
  end

endmodule

// File: rtl/ioport_strobe_dec.sv
module ioport_strobe_dec
  import ioport_pkg::*;
#(
  parameter int                  ADDR_W      = 16,
  parameter int                  NARROW_W    = 8,
  parameter int                  WIN_LOG2    = 3,
  parameter logic [NARROW_W-1:0] NARROW_BASE = 8'hF0,
  parameter logic [ADDR_W-1:0]   WIDE_BASE   = 16'hEFF8,
  localparam int NPORT = 1 << WIN_LOG2,
  localparam int NPAIR = NPORT / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wide_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_cycle,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              lane_lo_en,
  input  logic              lane_hi_en,
  input  logic              xfer_dword,
  output logic [NPORT-1:0]  port_sel_n,
  output logic [1:0]        wr_lane_n,
  output logic [NPAIR-1:0]  rd_pair_n,
  output logic              align_err
);

  bus_req_t         req;
  decode_mode_e     mode;
  logic             hit;
  logic [NPORT-1:0] port_mask;
  logic [1:0]       wr_lane;
  logic [NPAIR-1:0] rd_pair;
  logic             err_c;

  assign mode = decode_mode_e'(wide_mode);
  assign req  = '{io: io_cycle, rd: rd_cmd, wr: wr_cmd,
                  lo: lane_lo_en, hi: lane_hi_en, dword: xfer_dword};

  ioport_window_match #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .WIN_LOG2(WIN_LOG2),
    .NARROW_BASE(NARROW_BASE), .WIDE_BASE(WIDE_BASE)
  ) u_match (
    .addr(addr), .mode(mode), .hit(hit)
  );

  ioport_lane_select #(.WIN_LOG2(WIN_LOG2)) u_lanes (
    .offset(addr[WIN_LOG2-1:0]), .req(req), .hit(hit),
    .port_mask(port_mask), .wr_lane(wr_lane), .rd_pair(rd_pair),
    .align_err(err_c)
  );

  ioport_strobe_reg #(.NPORT(NPORT), .NPAIR(NPAIR)) u_reg (
    .clk(clk), .rst_n(rst_n),
    .port_mask(port_mask), .wr_lane(wr_lane), .rd_pair(rd_pair), .err_in(err_c),
    .port_sel_n(port_sel_n), .wr_lane_n(wr_lane_n), .rd_pair_n(rd_pair_n),
    .align_err(align_err)
  );

endmodule

// File: rtl/ioport_strobe_chk.sv
module ioport_strobe_chk #(
  parameter int NPORT = 8,
  parameter int NPAIR = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             io_cycle,
  input logic             rd_cmd,
  input logic             wr_cmd,
  input logic             xfer_dword,
  input logic [1:0]       addr_lo,
  input logic [NPORT-1:0] port_sel_n,
  input logic [1:0]       wr_lane_n,
  input logic [NPAIR-1:0] rd_pair_n,
  input logic             align_err
);

  logic all_idle;
  logic even_sel;
  logic odd_sel;

  assign all_idle = (&port_sel_n) && (&wr_lane_n) && (&rd_pair_n);

  always_comb begin
    even_sel = 1'b0;
    odd_sel  = 1'b0;
    for (int k = 0; k < NPAIR; k++) begin
      even_sel = even_sel | ~port_sel_n[2*k];
      odd_sel  = odd_sel  | ~port_sel_n[2*k + 1];
    end
  end

  AST_MEM_CYCLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(io_cycle) |-> all_idle); // R3
  AST_NO_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rd_cmd) && !$past(wr_cmd)) |-> all_idle); // R9
  AST_ERR_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> all_idle); // R8
  AST_ERR_NEEDS_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> ($past(xfer_dword) && ($past(addr_lo) != 2'b00))); // R8
  AST_READ_NO_WRLANE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_cmd) |-> (&wr_lane_n)); // R5
  AST_WRITE_NO_RDPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_cmd) |-> (&rd_pair_n)); // R6
  AST_LO_LANE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lane_n[0] |-> even_sel); // R5
  AST_HI_LANE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lane_n[1] |-> odd_sel); // R5
  AST_DWORD_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xfer_dword) && !(&port_sel_n)) |-> ($countones(~port_sel_n) == 4)); // R7

endmodule

bind ioport_strobe_dec ioport_strobe_chk #(.NPORT(NPORT), .NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_cycle(io_cycle), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
  .xfer_dword(xfer_dword), .addr_lo(addr[1:0]),
  .port_sel_n(port_sel_n), .wr_lane_n(wr_lane_n), .rd_pair_n(rd_pair_n),
  .align_err(align_err)
);

// File: tb/ioport_strobe_dec_tb_top.sv
module ioport_strobe_dec_tb_top;

  localparam int WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] addr = '0;
  logic        io_cycle = 1'b0;
  logic        rd_cmd = 1'b0;
  logic        wr_cmd = 1'b0;
  logic        lane_lo_en = 1'b0;
  logic        lane_hi_en = 1'b0;
  logic        xfer_dword = 1'b0;
  logic [7:0]  port_sel_n;
  logic [1:0]  wr_lane_n;
  logic [3:0]  rd_pair_n;
  logic        align_err;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 0;

  logic [7:0] e_sel;
  logic [1:0] e_wr;
  logic [3:0] e_rd;
  logic       e_err;
  string      e_tag;
  bit         have_exp = 0;

  always #10 clk = ~clk;  // 50 MHz

  ioport_strobe_dec dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .addr(addr),
    .io_cycle(io_cycle), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .lane_lo_en(lane_lo_en), .lane_hi_en(lane_hi_en), .xfer_dword(xfer_dword),
    .port_sel_n(port_sel_n), .wr_lane_n(wr_lane_n), .rd_pair_n(rd_pair_n),
    .align_err(align_err)
  );

  // Reference built from the requirements.
  task automatic model(input bit wm, input int a, input bit io, input bit rd, input bit wr,
                       input bit lo, input bit hi, input bit dw,
                       output logic [7:0] sel_n, output logic [1:0] wr_n,
                       output logic [3:0] rd_n, output logic err);
    int  off;
    int  lowb;
    int  mask;
    int  base;
    bit  hit;
    bit  act;
    bit  mis;
    off  = a % 8;
    lowb = a % 256;
    mask = 0;
    // R1 narrow window F0h-F7h on the low byte; R2 full EFF8h-EFFFh
    hit  = wm ? (a >= 'hEFF8 && a <= 'hEFFF) : (lowb >= 'hF0 && lowb <= 'hF7);
    act  = hit && io && (rd || wr);             // R3
    mis  = dw && ((a % 4) != 0);                // R8
    err  = act && mis;
    if (act && !mis) begin
      if (dw) mask = 15 << ((off / 4) * 4);     // R7
      else begin                                // R4
        base = (off / 2) * 2;
        mask = (int'(lo) << base) | (int'(hi) << (base + 1));
      end
    end
    sel_n   = ~mask[7:0];
    wr_n[0] = !(wr && ((mask & 'h55) != 0));    // R5
    wr_n[1] = !(wr && ((mask & 'hAA) != 0));
    for (int p = 0; p < 4; p++)                 // R6
      rd_n[p] = !(rd && (((mask >> (2 * p)) & 3) != 0));
  endtask

  task automatic compare_prev();
    string t;
    if (!have_exp) return;
    n_vec++;
    if (port_sel_n !== e_sel || wr_lane_n !== e_wr || rd_pair_n !== e_rd || align_err !== e_err) begin
      n_bad++;
      if (e_tag != "") t = e_tag;
      else if (align_err !== e_err) t = "R8";
      else if (port_sel_n !== e_sel) t = "R4";
      else if (wr_lane_n !== e_wr) t = "R5";
      else t = "R6";
      $display("FAIL %s sel=%h/%h wr=%b/%b rd=%b/%b err=%b/%b (actual/expected)",
               t, port_sel_n, e_sel, wr_lane_n, e_wr, rd_pair_n, e_rd, align_err, e_err);
    end
  endtask

  // Check the previous vector, then apply a new one.
  task automatic step(input bit wm, input int a, input bit io, input bit rd, input bit wr,
                      input bit lo, input bit hi, input bit dw, input string tag);
    @(negedge clk);
    compare_prev();
    wide_mode = wm; addr = 16'(a); io_cycle = io; rd_cmd = rd; wr_cmd = wr;
    lane_lo_en = lo; lane_hi_en = hi; xfer_dword = dw;
    model(wm, a, io, rd, wr, lo, hi, dw, e_sel, e_wr, e_rd, e_err);
    e_tag = tag;
    have_exp = 1;
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired after %0d cycles (expected completion)", WATCHDOG_CYC);
    finish_run();
  end

  initial begin : main
    int uppers[3];
    uppers = '{0, 'hEF, 'hFF};
    repeat (3) @(negedge clk);
    // R9 reset state
    n_vec++;
    if (port_sel_n !== 8'hFF || wr_lane_n !== 2'b11 || rd_pair_n !== 4'hF || align_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R9 reset sel=%h wr=%b rd=%b err=%b expected FF 11 1111 0",
               port_sel_n, wr_lane_n, rd_pair_n, align_err);
    end
    rst_n = 1'b1;

    // Directed cases.
    step(0, 'h12F2, 1, 0, 1, 1, 0, 0, "R1");  // upper byte ignored
    step(0, 'h00F2, 1, 0, 1, 1, 0, 0, "R1");
    step(1, 'h00F2, 1, 0, 1, 1, 0, 0, "R2");  // no hit in wide mode
    step(1, 'hEFFA, 1, 0, 1, 1, 1, 0, "R5");  // both lanes together
    step(0, 'h00F2, 0, 0, 1, 1, 1, 0, "R3");  // memory cycle
    step(0, 'h00F5, 1, 1, 0, 0, 1, 0, "R6");  // single pair read enable
    step(0, 'h00F3, 1, 0, 1, 1, 0, 0, "R4");  // addr[0] not decoded
    step(0, 'h00F4, 1, 1, 0, 0, 0, 1, "R7");  // aligned dword read
    step(1, 'hEFF8, 1, 0, 1, 0, 0, 1, "R7");  // aligned dword write
    step(0, 'h00F6, 1, 0, 1, 1, 1, 1, "R8");  // misaligned dword
    step(0, 'h00F6, 1, 0, 1, 1, 1, 0, "R5");
    step(0, 'h00F6, 1, 0, 0, 1, 1, 0, "R9");  // command removed

    // Sweep.
    for (int m = 0; m < 2; m++)
      for (int u = 0; u < 3; u++)
        for (int lb = 0; lb < 256; lb++)
          for (int c = 0; c < 64; c++)
            step(bit'(m), uppers[u] * 256 + lb, c[0], c[1], c[2], c[3], c[4], c[5], "");

    @(negedge clk);
    compare_prev();
    finish_run();
  end

endmodule